// File: doc/BRIEF.md
# Display Window Run Writer

This block places one horizontal run of 4-bit grayscale pixels on a 128 by 96 panel controller. Each byte holds two pixels, so a panel row is 64 bytes wide. A request gives a row, a starting pixel column and a pixel count. The block converts that request into a byte-addressed column window and a one-row window. It then sends the horizontal-increment mode command and streams the packed pixel bytes from a valid/ready source to a byte-wide transmit port. That port feeds a lower serial layer, and a command flag travels with every byte.

A separate clear request uses the same port to paint the whole panel black. It opens a full-screen window and sends black bytes for every row. Requests that the byte-wide path cannot honour are refused: odd alignment, a run that would pass the right edge of the panel, or a row past the bottom. A refused request raises a one-cycle error flag and puts nothing on the bus.

Top module: `run_window_writer`

## Requirements
- R1: During and just after reset, `busy`, `tx_valid`, `err`, `done` and `pix_ready` are all low.
- R2: An accepted run first sends three command bytes (`tx_cmd`=1): the column opcode 0x15, then col/2, then (col+npix)/2 - 1.
- R3: Next it sends three command bytes: the row opcode 0x75, then the row, then the same row again.
- R4: Next it sends two command bytes: the remap opcode 0xA0, then its horizontal-increment argument 0x52.
- R5: It then sends exactly npix/2 data bytes (`tx_cmd`=0). These are the pixel stream bytes, in arrival order and unchanged.
- R6: A run request with npix = 0 sends no bytes and raises neither `err` nor `done`, even when the column is odd.
- R7: A run request with an odd col, an odd npix, col+npix greater than 128, or a row of 96 or more sends no bytes. It raises `err` for exactly one cycle, in the cycle after the request.
- R8: A clear request sends the column window 0..63, the row window 0..95 and the increment command, all with the same opcodes as a run. It then sends 6144 data bytes of 0x00, which is black in both nibbles.
- R9: When the pixel stream is not valid, no data byte is sent. When `tx_ready` is low, the offered byte and its command flag are held unchanged until they are taken. No byte is lost or duplicated.
- R10: `done` pulses for one cycle after the last byte of a run or clear is taken, and `busy` is then low. Requests that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_go | input | 1 | One-cycle request to write a run |
| clear_go | input | 1 | One-cycle request to clear the panel; wins over run_go |
| row | input | 7 | Target pixel row |
| col | input | 8 | Starting pixel column |
| npix | input | 8 | Pixel count, 0 to 128 |
| pix_valid | input | 1 | Pixel byte available |
| pix_data | input | 8 | Two packed pixels |
| pix_ready | output | 1 | Pixel byte taken this cycle when pix_valid is high |
| tx_valid | output | 1 | Byte offered to the serial layer |
| tx_data | output | 8 | Offered byte |
| tx_cmd | output | 1 | 1 = command byte, 0 = data byte |
| tx_ready | input | 1 | Serial layer accepts the offered byte |
| busy | output | 1 | A run or clear is in progress |
| err | output | 1 | One-cycle pulse for a refused run |
| done | output | 1 | One-cycle pulse when a run or clear completes |

## Verification
A request is registered on the clock edge where `run_go` or `clear_go` is high. The first command byte is therefore offered in the next cycle, and `err` is high in that same next cycle. The bench drives inputs and samples outputs one time unit after the falling edge, and counts a byte only when `tx_valid` and `tx_ready` are both high there. That byte is transferred on the following rising edge, so the recorded stream matches the bus transfers exactly, whatever stalls occur. `done` is due in the cycle after the last byte is taken. After each request the bench waits twenty more idle cycles, so any extra or late bytes are also counted.

// File: rtl/run_window_writer.sv
module run_window_writer #(
  parameter int COLS      = 128,
  parameter int ROWS      = 96,
  parameter logic [7:0] OP_COL    = 8'h15,
  parameter logic [7:0] OP_ROW    = 8'h75,
  parameter logic [7:0] OP_REMAP  = 8'hA0,
  parameter logic [7:0] REMAP_ARG = 8'h52,
  parameter logic [7:0] FILL      = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_go,
  input  logic       clear_go,
  input  logic [6:0] row,
  input  logic [7:0] col,
  input  logic [7:0] npix,
  input  logic       pix_valid,
  input  logic [7:0] pix_data,
  output logic       pix_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_cmd,
  input  logic       tx_ready,
  output logic       busy,
  output logic       err,
  output logic       done
);
  localparam int ROW_BYTES = COLS / 2;
  localparam int TOTAL     = ROW_BYTES * ROWS;
  localparam int NW        = $clog2(TOTAL + 1);

  logic          in_data, is_clr;
  logic [2:0]    idx;
  logic [NW-1:0] left;
  logic [7:0]    w_c0, w_c1, w_r0, w_r1;
  logic [7:0]    cmd_byte;
  logic [8:0]    span;
  logic          bad, fire;

  assign span = {1'b0, col} + {1'b0, npix};
  assign bad  = col[0] | npix[0] | (32'(span) > COLS) | (32'(row) >= ROWS);

  assign tx_valid  = busy & (~in_data | is_clr | pix_valid);
  assign pix_ready = busy & in_data & ~is_clr & tx_ready;
  assign tx_cmd    = ~in_data;
  assign fire      = tx_valid & tx_ready;
  assign tx_data   = in_data ? (is_clr ? FILL : pix_data) : cmd_byte;

  always_comb begin
    case (idx)
      3'd0:    cmd_byte = OP_COL;
      3'd1:    cmd_byte = w_c0;
      3'd2:    cmd_byte = w_c1;
      3'd3:    cmd_byte = OP_ROW;
      3'd4:    cmd_byte = w_r0;
      3'd5:    cmd_byte = w_r1;
      3'd6:    cmd_byte = OP_REMAP;
      default: cmd_byte = REMAP_ARG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      in_data <= 1'b0;
      is_clr  <= 1'b0;
      idx     <= '0;
      left    <= '0;
      w_c0    <= '0;
      w_c1    <= '0;
      w_r0    <= '0;
      w_r1    <= '0;
      err     <= 1'b0;
      done    <= 1'b0;
    end else begin
      err  <= 1'b0;
      done <= 1'b0;
      if (!busy) begin
        if (clear_go) begin
          busy    <= 1'b1;
          in_data <= 1'b0;
          is_clr  <= 1'b1;
          idx     <= '0;
          left    <= NW'(TOTAL);
          w_c0    <= 8'd0;
          w_c1    <= 8'(ROW_BYTES - 1);
          w_r0    <= 8'd0;
          w_r1    <= 8'(ROWS - 1);
        end else if (run_go && npix != 8'd0) begin
          if (bad) begin
            err <= 1'b1;
          end else begin
            busy    <= 1'b1;
            in_data <= 1'b0;
            is_clr  <= 1'b0;
            idx     <= '0;
            left    <= NW'(npix >> 1);
            w_c0    <= 8'(col >> 1);
            w_c1    <= 8'((span >> 1) - 9'd1);
            w_r0    <= 8'(row);
            w_r1    <= 8'(row);
          end
        end
      end else if (fire) begin
        if (!in_data) begin
          idx <= idx + 3'd1;
          if (idx == 3'd7) in_data <= 1'b1;
        end else begin
          left <= left - NW'(1);
          if (left == NW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/run_window_writer_chk.sv
module run_window_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       err,
  input logic       done,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_cmd,
  input logic       pix_ready
);
  AST_ERR_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy); // R7
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_cmd)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_OPEN_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_cmd); // R2
  AST_PIX_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> busy && !tx_cmd); // R5
endmodule

bind run_window_writer run_window_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .done(done),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_cmd(tx_cmd), .pix_ready(pix_ready)
);

// File: tb/run_window_writer_bench.sv
module run_window_writer_bench;
  localparam logic [7:0] OP_COL = 8'h15, OP_ROW = 8'h75, OP_REMAP = 8'hA0, REMAP_ARG = 8'h52;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, run_go, clear_go;
  logic [6:0] row;
  logic [7:0] col, npix;
  logic       pix_valid, pix_ready, tx_valid, tx_cmd, tx_ready, busy, err, done;
  logic [7:0] pix_data, tx_data;

  run_window_writer u_run_window_writer (
    .clk(clk), .rst_n(rst_n), .run_go(run_go), .clear_go(clear_go),
    .row(row), .col(col), .npix(npix), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_cmd(tx_cmd), .tx_ready(tx_ready),
    .busy(busy), .err(err), .done(done)
  );

  int checks = 0, fails = 0;
  logic [7:0] src [0:63];
  int sidx;
  logic pend;
  bit gaps, stalls;
  logic [15:0] lf = 16'hACE1;
  int ncap, nerr, ndone, mis_at;
  logic [8:0] mis_act, mis_exp;
  int er, ec, en;
  bit eclr;

  function automatic logic [8:0] exp_at(int i);
    case (i)
      0: return {1'b1, OP_COL};
      1: return eclr ? 9'h100 : {1'b1, 8'(ec >> 1)};
      2: return eclr ? {1'b1, 8'd63} : {1'b1, 8'(((ec + en) >> 1) - 1)};
      3: return {1'b1, OP_ROW};
      4: return eclr ? 9'h100 : {1'b1, 8'(er)};
      5: return eclr ? {1'b1, 8'd95} : {1'b1, 8'(er)};
      6: return {1'b1, OP_REMAP};
      7: return {1'b1, REMAP_ARG};
      default: return eclr ? 9'h000 : {1'b0, src[(i - 8) % 64]};
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  initial begin
    pix_valid = 0; pix_data = 0; tx_ready = 0; pend = 0; sidx = 0;
    ncap = 0; nerr = 0; ndone = 0; mis_at = -1;
    forever begin
      @(negedge clk);
      if (pend) sidx++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (!(pix_valid && !pend)) pix_valid = gaps ? lf[0] : 1'b1;
      pix_data = src[sidx % 64];
      tx_ready = stalls ? lf[3] : 1'b1;
      #1;
      pend = pix_valid && pix_ready;
      if (tx_valid && tx_ready) begin
        if (mis_at < 0 && {tx_cmd, tx_data} !== exp_at(ncap)) begin
          mis_at = ncap; mis_act = {tx_cmd, tx_data}; mis_exp = exp_at(ncap);
        end
        ncap++;
      end
      if (err) nerr++;
      if (done) ndone++;
    end
  end

  task automatic launch(int r, int c, int n, bit clr, bit g, bit s);
    @(negedge clk); #2;
    for (int i = 0; i < 64; i++) src[i] = 8'((i * 37 + c + r * 3) & 255);
    er = r; ec = c; en = n; eclr = clr; gaps = g; stalls = s;
    ncap = 0; nerr = 0; ndone = 0; mis_at = -1; sidx = 0; pend = 0;
    row = 7'(r); col = 8'(c); npix = 8'(n);
    run_go = !clr; clear_go = clr;
    @(negedge clk); #2;
    run_go = 0; clear_go = 0;
  endtask

  task automatic settle(int lim);
    int t = 0;
    while (ndone == 0 && nerr == 0 && t < lim) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
  endtask

  task automatic good_run(int r, int c, int n, bit g, bit s);
    launch(r, c, n, 0, g, s);
    settle(2000);
    chk(ncap == 8 + n / 2, "R5 byte count", ncap, 8 + n / 2);
    chk(mis_at < 0, (g || s) ? "R2 R3 R4 R5 R9 sequence under stalls" : "R2 R3 R4 R5 sequence",
        int'(mis_act), int'(mis_exp));
    chk(ndone == 1 && nerr == 0, "R10 done pulse", ndone, 1);
  endtask

  initial begin
    rst_n = 0; run_go = 0; clear_go = 0; row = 0; col = 0; npix = 0; gaps = 0; stalls = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !tx_valid && !err && !done && !pix_ready, "R1 reset idle",
        int'({busy, tx_valid, err, done, pix_ready}), 0);
    rst_n = 1;
    @(negedge clk); #2;
    chk(!busy && !tx_valid && !err && !done, "R1 idle after reset",
        int'({busy, tx_valid, err, done}), 0);

    for (int c = 0; c < 128; c += 2) good_run(0, c, 128 - c, c[1], c[2]);
    for (int c = 0; c < 128; c += 2) good_run(95, c, 2, c[2], c[1]);
    for (int c = 0; c < 128; c += 16) good_run(47, c, 16, 1, 1);

    launch(7, 127, 0, 0, 0, 0); settle(30);
    chk(ncap == 0 && nerr == 0 && ndone == 0, "R6 zero run silent", ncap + nerr + ndone, 0);
    launch(7, 4, 0, 0, 0, 0); settle(30);
    chk(ncap == 0 && nerr == 0 && ndone == 0, "R6 zero run even col", ncap + nerr + ndone, 0);

    launch(5, 3, 4, 0, 0, 0); settle(30);
    chk(ncap == 0 && nerr == 1, "R7 odd column", ncap * 10 + nerr, 1);
    launch(5, 4, 3, 0, 0, 0); settle(30);
    chk(ncap == 0 && nerr == 1, "R7 odd count", ncap * 10 + nerr, 1);
    launch(5, 2, 128, 0, 0, 0); settle(30);
    chk(ncap == 0 && nerr == 1, "R7 right edge overflow", ncap * 10 + nerr, 1);
    launch(96, 0, 2, 0, 0, 0); settle(30);
    chk(ncap == 0 && nerr == 1, "R7 row out of range", ncap * 10 + nerr, 1);
    good_run(5, 0, 128, 0, 0);

    launch(10, 0, 128, 0, 1, 1);
    repeat (5) @(negedge clk);
    #2; row = 20; col = 4; npix = 2; run_go = 1; clear_go = 1;
    @(negedge clk); #2; run_go = 0; clear_go = 0;
    settle(2000);
    chk(ncap == 72 && mis_at < 0, "R10 requests ignored while busy", ncap, 72);

    launch(0, 0, 0, 1, 0, 0);
    settle(20000);
    chk(ncap == 8 + 6144, "R8 clear byte count", ncap, 8 + 6144);
    chk(mis_at < 0, "R8 clear sequence", int'(mis_act), int'(mis_exp));
    chk(ndone == 1, "R8 clear done", ndone, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule